// File: doc/BRIEF.md
# I2C Byte-Memory Target with Write Protection

This block is the target side of an I2C link that fronts a small byte-addressed memory. It samples the bus clock and data lines with the system clock and finds START, repeated START and STOP conditions. It moves bytes MSB first and handles the acknowledge slot on every ninth clock. It also keeps a bus-busy flag that a neighbouring block can watch. The data output is open-drain: `sda_oe_o` high means the pad pulls SDA low.

A controller addresses the block with its 7-bit target ID. On a write, it sends two pointer bytes and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. To read, the controller sets the pointer with an address-only write, issues a repeated START, and sends the ID with the read bit set. The target then returns bytes from the pointer until the controller answers a byte with NACK. A data byte aimed at an inclusive protected address window gets a NACK, is not stored, and ends the transfer.

The memory port is simple. `mem_addr_o` always carries the pointer. Read data must be valid in the same cycle. A write is a one-cycle `mem_we_o` pulse carrying `mem_wdata_o`.

Top module: `i2c_mem_target`

## Requirements
- R1: `busy_o` rises the cycle after a START is detected (SDA falling while SCL is high) and falls the cycle after a STOP (SDA rising while SCL is high). A repeated START leaves it high.
- R2: An ID byte whose upper 7 bits equal `DEV_ADDR` is acknowledged by driving SDA low during the ninth clock. Bit 0 of the ID selects the direction: 0 is write, 1 is read.
- R3: A non-matching ID byte is not acknowledged. Until the next START the target drives no SDA and writes nothing.
- R4: After a write ID, the first byte loads pointer bits [12:8] from its low 5 bits and the second byte loads bits [7:0]. Both bytes are acknowledged.
- R5: Each later write byte is acknowledged, stored at the pointer, and followed by a pointer increment. The pointer wraps from 0x1FFF to 0x0000.
- R6: A data byte whose pointer lies in [`WP_LO`, `WP_HI`] is NACKed and not stored. Every later byte is ignored until a STOP or repeated START.
- R7: An address-only write is acknowledged even when the pointer lies inside the protected window. A following repeated START and read returns data from that pointer.
- R8: A read returns bytes MSB first from consecutive addresses starting at the pointer. The pointer advances once per byte sent.
- R9: A controller NACK on a read byte ends the read. The target then leaves SDA released until the next START.
- R10: `sda_oe_o` changes only while the synchronized SCL is low.
- R11: A repeated START returns the target to expecting an ID byte, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when high |
| busy_o | output | 1 | Bus busy between START and STOP |
| mem_addr_o | output | AW | Current byte pointer |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o`, same cycle |
| mem_wdata_o | output | 8 | Byte to be written |
| mem_we_o | output | 1 | One-cycle write strobe |

## Verification
Four properties are checked on every cycle:
- The open-drain enable only changes while SCL is low.
- The busy flag follows START and STOP.
- A write strobe never lands inside the protected window.
- The pointer advances by exactly one after every stored byte.

Other behaviours can only be shown by the directed scenarios:
- ID matching and the acknowledge bit levels.
- Pointer loading from the two address bytes and wrap at the top address.
- Abort after a protect NACK or a controller NACK.
- Recovery through a repeated START.
- The data returned by sequential reads.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA moving while SCL stays high is a bus condition, never data
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_tgt_wp.sv
module i2c_tgt_wp #(
  parameter int          AW    = 13,
  parameter logic [AW-1:0] WP_LO = 13'h1000,
  parameter logic [AW-1:0] WP_HI = 13'h10FF
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  assign hit_o = (addr_i >= WP_LO) && (addr_i <= WP_HI);
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int         AW       = 13,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          wp_hit_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] ptr_o,
  output logic [7:0]    wdata_o,
  output logic          we_o,
  output logic          sda_oe_o,
  output logic          busy_o
);
  localparam int HI_W = AW - 8;
  localparam logic [3:0] ACK_CNT = 4'd8;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  tgt_state_e state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          oe_q, busy_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      wdata_o <= '0;
    end else begin
      we_q <= 1'b0;
      if (we_q) ptr_q <= ptr_q + ONE;
      if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        busy_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (start_i) begin
        state_q <= ST_ID;
        oe_q    <= 1'b0;
        busy_q  <= 1'b1;
        cnt_q   <= '0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise_i) begin
          if (cnt_q != ACK_CNT) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else begin
            cnt_q <= '0;
            // controller NACK on a read byte ends the read
            if (state_q == ST_RD && sda_i) state_q <= ST_IDLE;
          end
        end else if (scl_fall_i) begin
          if (cnt_q == ACK_CNT) begin
            oe_q <= 1'b0;
            unique case (state_q)
              ST_ID: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  oe_q    <= 1'b1;
                  state_q <= sh_q[0] ? ST_RD : ST_AHI;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                oe_q    <= 1'b1;
                ptr_q   <= {sh_q[HI_W-1:0], ptr_q[7:0]};
                state_q <= ST_ALO;
              end
              ST_ALO: begin
                oe_q    <= 1'b1;
                ptr_q   <= {ptr_q[AW-1:8], sh_q};
                state_q <= ST_WR;
              end
              ST_WR: begin
                if (wp_hit_i) begin
                  state_q <= ST_IDLE;
                end else begin
                  oe_q    <= 1'b1;
                  we_q    <= 1'b1;
                  wdata_o <= sh_q;
                end
              end
              default: ;
            endcase
          end else if (state_q == ST_RD) begin
            if (cnt_q == 4'd0) begin
              oe_q  <= ~rdata_i[7];
              tx_q  <= {rdata_i[6:0], 1'b0};
              ptr_q <= ptr_q + ONE;
            end else begin
              oe_q <= ~tx_q[7];
              tx_q <= {tx_q[6:0], 1'b0};
            end
          end else begin
            oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign ptr_o    = ptr_q;
  assign we_o     = we_q;
  assign sda_oe_o = oe_q;
  assign busy_o   = busy_q;

  p_sda_on_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !$past(scl_i));
  p_busy_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
  p_busy_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_q);
  p_no_prot_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> !wp_hit_i);
  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> ptr_q == $past(ptr_q) + ONE);
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int            AW       = 13,
  parameter logic [6:0]    DEV_ADDR = 7'h50,
  parameter logic [AW-1:0] WP_LO    = 13'h1000,
  parameter logic [AW-1:0] WP_HI    = 13'h10FF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop, wp_hit;

  i2c_tgt_line_mon #(.SYNC_STAGES(2)) u_line (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_tgt_wp #(.AW(AW), .WP_LO(WP_LO), .WP_HI(WP_HI)) u_wp (
    .addr_i(mem_addr_o), .hit_o(wp_hit)
  );

  i2c_tgt_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .wp_hit_i(wp_hit), .rdata_i(mem_rdata_i),
    .ptr_o(mem_addr_o), .wdata_o(mem_wdata_o), .we_o(mem_we_o),
    .sda_oe_o, .busy_o
  );
endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
  localparam int Q = 10;
  localparam logic [7:0] WID = 8'hA0;
  localparam logic [7:0] RID = 8'hA1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, busy, we;
  logic [12:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [256];
  wire sda_line = sda_m & ~sda_oe;
  int total = 0, bad = 0, we_cnt = 0, r10_viol = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  i2c_mem_target uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_o(busy), .mem_addr_o(addr),
    .mem_rdata_i(rdata), .mem_wdata_o(wdata), .mem_we_o(we)
  );

  assign rdata = mem[addr[7:0]];

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
    end else if (we) begin
      mem[addr[7:0]] <= wdata;
      we_cnt <= we_cnt + 1;
    end
    // R10 monitor: output enable must not move while SCL is high
    if (rst_ni && sda_oe != oe_prev && scl_m) r10_viol <= r10_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = ~sda_line;
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = nack; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [12:0] p);
    bit a;
    bus_start();
    send_byte(WID, a);      check(a, "R2 write id ack", a, 1);
    send_byte({3'b000, p[12:8]}, a); check(a, "R4 addr hi ack", a, 1);
    send_byte(p[7:0], a);   check(a, "R4 addr lo ack", a, 1);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 busy at reset", busy, 0);
    check(sda_oe == 1'b0, "R10 oe at reset", sda_oe, 0);
    check(we == 1'b0, "R5 we at reset", we, 0);
  endtask

  task automatic t_write_basic();
    bit a;
    set_ptr(13'h0010);
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    send_byte(8'hA1, a); check(a, "R5 data ack", a, 1);
    send_byte(8'hB2, a); check(a, "R5 data ack", a, 1);
    send_byte(8'hC3, a); check(a, "R5 data ack", a, 1);
    bus_stop();
    check(busy == 1'b0, "R1 busy after stop", busy, 0);
    check(mem[8'h10] == 8'hA1, "R5 mem 10", mem[8'h10], 8'hA1);
    check(mem[8'h11] == 8'hB2, "R5 mem 11", mem[8'h11], 8'hB2);
    check(mem[8'h12] == 8'hC3, "R5 mem 12", mem[8'h12], 8'hC3);
    check(addr == 13'h0013, "R5 ptr after writes", addr, 13'h0013);
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] b;
    set_ptr(13'h0010);
    bus_start();
    check(busy == 1'b1, "R1 busy across repeated start", busy, 1);
    send_byte(RID, a); check(a, "R11 read id ack after Sr", a, 1);
    recv_byte(1'b0, b); check(b == 8'hA1, "R8 read 0", b, 8'hA1);
    recv_byte(1'b0, b); check(b == 8'hB2, "R8 read 1", b, 8'hB2);
    recv_byte(1'b1, b); check(b == 8'hC3, "R8 read 2", b, 8'hC3);
    recv_byte(1'b1, b); check(b == 8'hFF, "R9 released after nack", b, 8'hFF);
    check(sda_oe == 1'b0, "R9 oe after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_wrap();
    bit a;
    set_ptr(13'h1FFF);
    send_byte(8'h5A, a); check(a, "R5 top ack", a, 1);
    send_byte(8'h6B, a); check(a, "R5 wrap ack", a, 1);
    bus_stop();
    check(mem[8'hFF] == 8'h5A, "R5 mem 1fff", mem[8'hFF], 8'h5A);
    check(mem[8'h00] == 8'h6B, "R5 wrap to 0", mem[8'h00], 8'h6B);
    check(addr == 13'h0001, "R5 ptr wrapped", addr, 13'h0001);
  endtask

  task automatic t_bad_id();
    bit a;
    int w0 = we_cnt;
    bus_start();
    send_byte(8'h42, a); check(!a, "R3 foreign id nack", a, 0);
    send_byte(8'h00, a); check(!a, "R3 ignored byte", a, 0);
    send_byte(8'h20, a); check(!a, "R3 ignored byte", a, 0);
    check(we_cnt == w0, "R3 no write", we_cnt, w0);
    bus_stop();
  endtask

  task automatic t_protect();
    bit a;
    int w0 = we_cnt;
    set_ptr(13'h1005);
    send_byte(8'h77, a); check(!a, "R6 protected nack", a, 0);
    send_byte(8'h88, a); check(!a, "R6 aborted byte", a, 0);
    check(we_cnt == w0, "R6 nothing stored", we_cnt, w0);
    check(mem[8'h05] == (8'h05 ^ 8'h3C), "R6 mem kept", mem[8'h05], 8'h05 ^ 8'h3C);
    bus_start();
    send_byte(WID, a); check(a, "R11 id after Sr from abort", a, 1);
    bus_stop();
  endtask

  task automatic t_addr_only_prot();
    bit a;
    logic [7:0] b;
    set_ptr(13'h1020);
    bus_start();
    send_byte(RID, a); check(a, "R7 read id ack", a, 1);
    recv_byte(1'b1, b); check(b == (8'h20 ^ 8'h3C), "R7 read protected ptr", b, 8'h20 ^ 8'h3C);
    bus_stop();
  endtask

  initial begin
    wq(5);
    rst_ni = 1'b1;
    wq(5);
    t_reset();
    t_write_basic();
    t_read();
    t_wrap();
    t_bad_id();
    t_protect();
    t_addr_only_prot();
    wq(10);
    check(r10_viol == 0, "R10 oe moved with SCL high", r10_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule